// File: doc/BRIEF.md
# Windowed Clock Frequency Meter

The block measures a clock against a reference. Software picks a measured clock and a fixed clock. It sets a window length and starts the meter. The meter then counts rising edges of the measured clock over a whole number of fixed-clock periods and stores the total in a data register. This lets software compare an oscillator with a reference crystal, for example to trim a slow oscillator.

Every clock source is modelled as a one-cycle edge strobe. Each strobe is sampled in the single system clock domain, and each selectable source has its own strobe bit. There are two strobe vectors, one for measured sources and one for fixed sources, and each is indexed by its own 3-bit select code. Software uses a small register interface with four word addresses. It writes the control word, polls a busy flag and reads the result.

Top module: `freq_meter`

## Requirements
- R1: After reset, all four addresses read 0, so busy is 0.
- R2: Address 0 is the control word. Bits [2:0] select the measured source, bit 4 enables the reference path, bit 15 is the meter enable, and bit 3 is a read-only busy flag. Address 1 holds the window value N. Address 2 is the read-only result. Address 3 bits [2:0] select the fixed source and address 3 bit 8 is the soft reset. Writes to bit 3 and to address 2 have no effect.
- R3: Writing the control word with bit 15 set starts a measurement when all three of these hold: bit 15 was 0, bit 4 was already 1 before the write, and bit 4 is kept set in the written value. Busy reads 1 from the next cycle.
- R4: Setting bit 15 when bit 4 was not already set does not start a measurement. Busy stays 0 and the result is unchanged.
- R5: The gate opens at the first selected fixed strobe after the start. It closes at the (N+1)-th fixed strobe after that, so N=0 is one fixed period. The result is the number of measured strobes in the cycles after the opening strobe, up to and including the closing one. A strobe every cycle against a 794-cycle fixed period with N=0 gives 794.
- R6: Measured code k selects measured strobe k, and fixed code k selects fixed strobe k, for every k from 0 to 7.
- R7: Busy drops at the same edge at which the result is stored. The result then holds until the next start. Leaving bit 15 set does not start another measurement.
- R8: The count saturates at 0xFFFF and does not wrap.
- R9: Clearing bit 15 while busy aborts the measurement. Busy reads 0 and the previous result is kept.
- R10: While the soft-reset bit is 1, busy reads 0 and the result reads 0, and any running measurement is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| meas_tick | input | 8 | Edge strobes of the measured-clock candidates |
| fix_tick | input | 8 | Edge strobes of the fixed-clock candidates |

## Verification
Saturation is the hardest case to reach from the ports, because the gate must stay open for more than 65535 measured edges. The stimulus stretches one fixed source to a 33000-cycle period and selects a measured source that strobes every cycle. With a window of 1, the true count is 66000, which is past the limit. The exact close cycle is also hard to observe. The stimulus therefore generates every strobe from known periods and phases, derives the opening and closing cycles, and checks that busy falls exactly at the computed cycle.

// File: rtl/freq_meter.sv
module freq_meter #(
  parameter int CNT_W = 16,
  parameter int WIN_W = 16,
  parameter int SEL_W = 3,
  localparam int NSRC = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [15:0]      wdata,
  output logic [15:0]      rdata,
  input  logic [NSRC-1:0]  meas_tick,
  input  logic [NSRC-1:0]  fix_tick
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [SEL_W-1:0] msel_q, fsel_q;
  logic             ref_q, en_q, srst_q, busy_q, gate_q;
  logic [WIN_W-1:0] win_q, pcnt_q;
  logic [CNT_W-1:0] cnt_q, data_q;

  wire ctrl_wr = wr_en && addr == 2'd0;
  wire start   = ctrl_wr && wdata[15] && !en_q && ref_q && wdata[4];
  wire stop    = ctrl_wr && !wdata[15] && busy_q;
  wire mtk     = meas_tick[msel_q];
  wire ftk     = fix_tick[fsel_q];
  wire [CNT_W-1:0] cnt_nx = (mtk && cnt_q != CMAX) ? cnt_q + CNT_W'(1) : cnt_q;

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: begin
        rdata[15] = en_q;
        rdata[4]  = ref_q;
        rdata[3]  = busy_q;
        rdata[SEL_W-1:0] = msel_q;
      end
      2'd1: rdata[WIN_W-1:0] = win_q;
      2'd2: rdata[CNT_W-1:0] = data_q;
      default: begin
        rdata[8] = srst_q;
        rdata[SEL_W-1:0] = fsel_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msel_q <= '0; fsel_q <= '0; ref_q <= 1'b0; en_q <= 1'b0;
      srst_q <= 1'b0; win_q <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0: begin
          msel_q <= wdata[SEL_W-1:0];
          ref_q  <= wdata[4];
          en_q   <= wdata[15];
        end
        2'd1: win_q <= wdata[WIN_W-1:0];
        2'd3: begin
          fsel_q <= wdata[SEL_W-1:0];
          srst_q <= wdata[8];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; gate_q <= 1'b0; pcnt_q <= '0; cnt_q <= '0; data_q <= '0;
    end else if (srst_q) begin
      busy_q <= 1'b0; gate_q <= 1'b0; pcnt_q <= '0; cnt_q <= '0; data_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1; gate_q <= 1'b0; pcnt_q <= '0; cnt_q <= '0;
    end else if (stop) begin
      busy_q <= 1'b0; gate_q <= 1'b0;
    end else if (busy_q) begin
      if (!gate_q) begin
        if (ftk) gate_q <= 1'b1;
      end else begin
        cnt_q <= cnt_nx;
        if (ftk) begin
          if (pcnt_q == win_q) begin
            data_q <= cnt_nx;
            busy_q <= 1'b0;
            gate_q <= 1'b0;
          end else begin
            pcnt_q <= pcnt_q + WIN_W'(1);
          end
        end
      end
    end
  end

  assert_start_needs_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ref_q);

  assert_result_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(busy_q) && !$past(srst_q)) |-> $stable(data_q));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CMAX && !start && !srst_q) |=> cnt_q == CMAX);

  assert_soft_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (!busy_q && data_q == '0));
endmodule

// File: tb/test_freq_meter.sv
module test_freq_meter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0] meas_tick = '0;
  logic [7:0] fix_tick = '0;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int last_we = 0;
  int mp[8] = '{3, 5, 7, 2, 1, 4, 6, 9};
  int fp[8] = '{50, 37, 794, 23, 64, 41, 29, 71};

  freq_meter i_freq_meter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .meas_tick(meas_tick), .fix_tick(fix_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int i = 0; i < 8; i++) begin
      meas_tick[i] <= ((cyc + 1) % mp[i]) == 0;
      fix_tick[i]  <= ((cyc + 1) % fp[i]) == (i % fp[i]);
    end
  end

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) if (cyc > WATCHDOG) begin
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
    report();
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; last_we = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  function automatic longint upto(longint x, int p, int ph);
    return (x < ph) ? 0 : (x - ph) / p + 1;
  endfunction

  // start (bit4 pre-set), compute expected, poll busy and check timing and value
  task automatic measure(input int ms, input int fs, input int w, input string req,
                         output int got);
    logic [15:0] v;
    longint t0, te, e;
    int pf, ph;
    wr(2'd3, 16'(fs));
    wr(2'd1, 16'(w));
    wr(2'd0, 16'h0010 | 16'(ms));
    wr(2'd0, 16'h8010 | 16'(ms));
    pf = fp[fs]; ph = fs % pf;
    t0 = last_we + 1 + ((ph - (last_we + 1) % pf + pf) % pf);
    te = t0 + longint'(w + 1) * pf;
    e = upto(te, mp[ms], 0) - upto(t0, mp[ms], 0);
    if (e > 65535) e = 65535;
    rd(2'd0, v);
    chk("R3 busy after start", int'(v[3]), 1);
    do rd(2'd0, v); while (v[3]);
    chk("R7 busy falls at gate close", cyc, int'(te));
    rd(2'd2, v);
    got = int'(v);
    chk(req, got, int'(e));
  endtask

  initial begin
    logic [15:0] v;
    int got, prev, seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reset value", int'(v), 0);
    end

    // R2 register fields
    wr(2'd0, 16'h0015); rd(2'd0, v); chk("R2 control readback", int'(v), 16'h0015);
    wr(2'd0, 16'h001D); rd(2'd0, v); chk("R2 busy bit not writable", int'(v), 16'h0015);
    wr(2'd1, 16'h1234); rd(2'd1, v); chk("R2 window readback", int'(v), 16'h1234);
    wr(2'd3, 16'h0003); rd(2'd3, v); chk("R2 fixed select readback", int'(v), 3);
    wr(2'd2, 16'hBEEF); rd(2'd2, v); chk("R2 result read-only", int'(v), 0);

    // R4 enable without prior reference path enable
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h8014);
    repeat (100) @(negedge clk);
    rd(2'd0, v); chk("R4 no start busy", int'(v[3]), 0);
    rd(2'd2, v); chk("R4 result unchanged", int'(v), 0);
    wr(2'd0, 16'h0014);

    // R5 ratio 794, one window period
    measure(4, 2, 0, "R5 count ratio 794", got);
    chk("R5 literal 794", got, 794);

    // R7 hold with enable left set
    repeat (1000) @(negedge clk);
    rd(2'd0, v); chk("R7 no restart", int'(v[3]), 0);
    rd(2'd2, v); chk("R7 result held", int'(v), 794);
    wr(2'd0, 16'h0014);

    // R5 multi-period window
    measure(0, 0, 3, "R5 window N=3", got);
    wr(2'd0, 16'h0010);
    prev = got;

    // R9 abort by clearing enable
    wr(2'd3, 16'h0002); wr(2'd1, 16'h0002);
    wr(2'd0, 16'h0014); wr(2'd0, 16'h8014);
    repeat (300) @(negedge clk);
    rd(2'd0, v); chk("R3 busy mid window", int'(v[3]), 1);
    wr(2'd0, 16'h0014);
    rd(2'd0, v); chk("R9 busy cleared by stop", int'(v[3]), 0);
    repeat (3000) @(negedge clk);
    rd(2'd2, v); chk("R9 result kept", int'(v), prev);

    // R10 soft reset during measurement
    wr(2'd0, 16'h8014);
    repeat (200) @(negedge clk);
    wr(2'd3, 16'h0102);
    rd(2'd0, v); chk("R10 busy cleared by soft reset", int'(v[3]), 0);
    rd(2'd2, v); chk("R10 result cleared", int'(v), 0);
    wr(2'd3, 16'h0002);
    repeat (3000) @(negedge clk);
    rd(2'd0, v); chk("R10 stays idle", int'(v[3]), 0);
    wr(2'd0, 16'h0014);

    // R6 random source selects
    for (int t = 0; t < 10; t++) begin
      int ms, fs, w;
      ms = int'($urandom % 8); fs = int'($urandom % 8); w = int'($urandom % 3);
      measure(ms, fs, w, "R6 selected sources", got);
      wr(2'd0, 16'h0010);
    end

    // R8 saturation
    fp[7] = 33000;
    measure(4, 7, 1, "R8 saturated count", got);
    chk("R8 literal max", got, 65535);
    wr(2'd0, 16'h0010);
    fp[7] = 71;

    report();
  end
endmodule